// File: doc/BRIEF.md
# Plotter Write Handshake Controller

This block is the small group of control latches that paces character transfers from a processor to an incremental plotter. A service response from the memory side raises the translator gate, which lets the output translator pass the current character. The plotter acknowledge drops that gate and opens a response window one clock long. During a plotter write, a record mark on the select channel inside that window sets a release latch. The release latch shuts the write path until the next instruction-cycle reset.

A parity watcher also runs on every character that reaches the translator while the gate is up. If the character has an even number of one bits, the watcher sets a check latch. That latch lights the check lamp and supplies a branch condition. Either the check-reset key clears it, or a branch test that reads it. Memory addressing and character decoding live elsewhere.

The operation type picks how record marks are treated. Both write modes stop on a mark. The dump mode ignores marks and runs on until the processor ends the operation through an instruction-cycle reset.

Top module: `plotter_wr_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is 0.
- R2: `xlat_gate` goes to 1 on the clock edge where `svc_resp` is 1. It goes to 0 on the edge where `plot_ack` is 1 and `svc_resp` is 0. When both are 1 on the same edge, it goes to 1.
- R3: `ack_window` is 1 for exactly the cycle after an edge where `plot_ack` was 1 and `ack_window` was 0. It is always 0 in the cycle after a cycle in which it was 1, so a held `plot_ack` makes it alternate 1,0,1.
- R4: An edge with `wr_start`=1 and `op_mode` not 2'b00 turns the write latch on. With `op_mode`=2'b00, `wr_start` has no effect. `write_en` is 1 while the write latch is on and `wr_release` is 0.
- R5: In a write mode (`op_mode` 2'b01 numeric or 2'b11 character), an edge where `ack_window`, `write_en` and `rec_mark` are all 1 sets `wr_release`. From the following cycle on, `write_en` is 0. A `rec_mark` outside the window has no effect.
- R6: In dump mode (`op_mode`=2'b10), `rec_mark` is ignored. `wr_release` stays 0 and `write_en` stays 1.
- R7: `wr_release` stays set until an edge with `icycle_rst`=1. That edge clears it and also turns the write latch off. If a release condition arrives on the same edge, the release stays set.
- R8: The check latch sets on an edge where `char_strobe`=1, `xlat_gate`=1 and `out_char` holds an even number of one bits (zero counts as even). A character with an odd count, or a strobe while the gate is 0, leaves the latch unchanged.
- R9: An edge with `chk_reset_key` or `branch_test` at 1 clears the check latch, unless the R8 set condition holds on that same edge.
- R10: `check_light` and `branch_cond` show the check latch directly. In the cycle `branch_test` is raised, `branch_cond` still shows the value from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| svc_resp | input | 1 | Memory-side service response |
| plot_ack | input | 1 | Plotter acknowledge response |
| rec_mark | input | 1 | Select channel carries a record mark |
| op_mode | input | 2 | 00 none, 01 numeric write, 10 dump, 11 character write |
| wr_start | input | 1 | Begin a plotter output operation |
| char_strobe | input | 1 | A character is presented to the translator |
| out_char | input | CHAR_W | Bits of the presented character |
| icycle_rst | input | 1 | Instruction-cycle reset |
| chk_reset_key | input | 1 | Operator check-reset key |
| branch_test | input | 1 | Branch instruction is testing the check latch |
| xlat_gate | output | 1 | Output translator gate |
| ack_window | output | 1 | One-cycle response window |
| write_en | output | 1 | Writing to the plotter is allowed |
| wr_release | output | 1 | Record mark ended the write |
| check_light | output | 1 | Write check lamp |
| branch_cond | output | 1 | Testable write-check condition |

## Verification
The bench builds the block with `CHAR_W` set to 6, which is the width of a plotter character code. At that width it can present a zero character, a full character with all six bits set, and characters with a single bit set. These cover both parity outcomes and both ends of the bit-count range. With the narrow width, every parity case can be written out by hand, while the XOR reduction still spans the whole word.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        OP_NONE     = 2'b00,
        OP_WR_NUM   = 2'b01,
        OP_DUMP     = 2'b10,
        OP_WR_ALPHA = 2'b11
    } pwc_op_e;

    typedef struct packed {
        logic gate;
        logic window;
    } pwc_hs_t;

    typedef struct packed {
        logic wr_on;
        logic rel;
    } pwc_rec_t;

    // Modes in which a record mark closes the write path.
    function automatic logic stops_on_mark(pwc_op_e op);
        return (op == OP_WR_NUM) || (op == OP_WR_ALPHA);
    endfunction

    // Modes that drive data to the plotter at all.
    function automatic logic is_output_op(pwc_op_e op);
        return op != OP_NONE;
    endfunction

endpackage

// File: rtl/pwc_handshake.sv
module pwc_handshake
    import pwc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    svc_resp,
    input  logic    plot_ack,
    output pwc_hs_t hs
);

    pwc_hs_t hs_q;
    pwc_hs_t hs_d;

    always_comb begin
        hs_d = hs_q;
        // Gate: set has priority over clear.
        if (svc_resp)
            hs_d.gate = 1'b1;
        else if (plot_ack)
            hs_d.gate = 1'b0;
        // Window: self-clearing one cycle after it sets.
        if (hs_q.window)
            hs_d.window = 1'b0;
        else
            hs_d.window = plot_ack;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hs_q <= '0;
        else
            hs_q <= hs_d;
    end

    assign hs = hs_q;

endmodule

// File: rtl/pwc_record.sv
module pwc_record
    import pwc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwc_op_e  op_mode,
    input  logic     wr_start,
    input  logic     window,
    input  logic     rec_mark,
    input  logic     icycle_rst,
    output pwc_rec_t rec,
    output logic     wr_allowed
);

    pwc_rec_t rec_q;
    pwc_rec_t rec_d;
    logic     rel_set;

    assign wr_allowed = rec_q.wr_on & ~rec_q.rel;
    assign rel_set    = window & wr_allowed & rec_mark & stops_on_mark(op_mode);

    always_comb begin
        rec_d = rec_q;
        if (rel_set)
            rec_d.rel = 1'b1;
        else if (icycle_rst)
            rec_d.rel = 1'b0;

        if (rec_q.rel && !icycle_rst)
            rec_d.wr_on = 1'b0;
        else if (wr_start && is_output_op(op_mode))
            rec_d.wr_on = 1'b1;
        else if (icycle_rst)
            rec_d.wr_on = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rec_q <= '0;
        else
            rec_q <= rec_d;
    end

    assign rec = rec_q;

endmodule

// File: rtl/pwc_wcheck.sv
module pwc_wcheck #(
    parameter int CHAR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    input  logic              char_strobe,
    input  logic [CHAR_W-1:0] out_char,
    input  logic              chk_reset_key,
    input  logic              branch_test,
    output logic              chk
);

    localparam int PAR_W = CHAR_W;

    logic [PAR_W-1:0] par_chain;
    logic             even_bits;
    logic             chk_q;

    // Ripple of partial parities across the character.
    genvar gi;
    generate
        for (gi = 0; gi < PAR_W; gi++) begin : g_par
            if (gi == 0) begin : g_first
                assign par_chain[gi] = out_char[gi];
            end else begin : g_next
                assign par_chain[gi] = par_chain[gi-1] ^ out_char[gi];
            end
        end
    endgenerate

    assign even_bits = ~par_chain[PAR_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            chk_q <= 1'b0;
        else if (char_strobe && gate && even_bits)
            chk_q <= 1'b1;
        else if (chk_reset_key || branch_test)
            chk_q <= 1'b0;
    end

    assign chk = chk_q;

endmodule

// File: rtl/plotter_wr_ctrl.sv
module plotter_wr_ctrl
    import pwc_pkg::*;
#(
    parameter int CHAR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_resp,
    input  logic              plot_ack,
    input  logic              rec_mark,
    input  logic [1:0]        op_mode,
    input  logic              wr_start,
    input  logic              char_strobe,
    input  logic [CHAR_W-1:0] out_char,
    input  logic              icycle_rst,
    input  logic              chk_reset_key,
    input  logic              branch_test,
    output logic              xlat_gate,
    output logic              ack_window,
    output logic              write_en,
    output logic              wr_release,
    output logic              check_light,
    output logic              branch_cond
);

    pwc_hs_t  hs;
    pwc_rec_t rec;
    pwc_op_e  op;
    logic     wr_allowed;
    logic     chk;

    assign op = pwc_op_e'(op_mode);

    pwc_handshake u_hs (
        .clk      (clk),
        .rst      (rst),
        .svc_resp (svc_resp),
        .plot_ack (plot_ack),
        .hs       (hs)
    );

    pwc_record u_rec (
        .clk        (clk),
        .rst        (rst),
        .op_mode    (op),
        .wr_start   (wr_start),
        .window     (hs.window),
        .rec_mark   (rec_mark),
        .icycle_rst (icycle_rst),
        .rec        (rec),
        .wr_allowed (wr_allowed)
    );

    pwc_wcheck #(.CHAR_W(CHAR_W)) u_chk (
        .clk           (clk),
        .rst           (rst),
        .gate          (hs.gate),
        .char_strobe   (char_strobe),
        .out_char      (out_char),
        .chk_reset_key (chk_reset_key),
        .branch_test   (branch_test),
        .chk           (chk)
    );

    assign xlat_gate   = hs.gate;
    assign ack_window  = hs.window;
    assign write_en    = wr_allowed;
    assign wr_release  = rec.rel;
    assign check_light = chk;
    assign branch_cond = chk;

endmodule

// File: rtl/plotter_wr_ctrl_chk.sv
module plotter_wr_ctrl_chk #(
    parameter int CHAR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              svc_resp,
    input logic              plot_ack,
    input logic              rec_mark,
    input logic [1:0]        op_mode,
    input logic              char_strobe,
    input logic [CHAR_W-1:0] out_char,
    input logic              icycle_rst,
    input logic              xlat_gate,
    input logic              ack_window,
    input logic              write_en,
    input logic              wr_release,
    input logic              check_light
);

    a_r2_gate_sets: assert property (@(posedge clk) disable iff (rst)
        svc_resp |=> xlat_gate);

    a_r2_gate_clears: assert property (@(posedge clk) disable iff (rst)
        (plot_ack && !svc_resp) |=> !xlat_gate);

    a_r3_window_single: assert property (@(posedge clk) disable iff (rst)
        ack_window |=> !ack_window);

    a_r3_window_opens: assert property (@(posedge clk) disable iff (rst)
        (plot_ack && !ack_window) |=> ack_window);

    a_r6_dump_no_release: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'b10 && !wr_release) |=> !wr_release);

    a_r7_release_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_release && !icycle_rst) |=> wr_release);

    a_r5_release_stops_write: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_release) |-> !write_en);

    a_r8_odd_no_set: assert property (@(posedge clk) disable iff (rst)
        (!check_light && char_strobe && ^out_char) |=> !check_light);

    a_r5_mark_outside_window: assert property (@(posedge clk) disable iff (rst)
        (!wr_release && !ack_window) |=> !wr_release);

endmodule

bind plotter_wr_ctrl plotter_wr_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk_bind (
    .clk         (clk),
    .rst         (rst),
    .svc_resp    (svc_resp),
    .plot_ack    (plot_ack),
    .rec_mark    (rec_mark),
    .op_mode     (op_mode),
    .char_strobe (char_strobe),
    .out_char    (out_char),
    .icycle_rst  (icycle_rst),
    .xlat_gate   (xlat_gate),
    .ack_window  (ack_window),
    .write_en    (write_en),
    .wr_release  (wr_release),
    .check_light (check_light)
);

// File: tb/plotter_wr_ctrl_bench.sv
module plotter_wr_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CHAR_W     = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic              svc_resp, plot_ack, rec_mark, wr_start, char_strobe;
    logic [1:0]        op_mode;
    logic [CHAR_W-1:0] out_char;
    logic              icycle_rst, chk_reset_key, branch_test;
    logic              xlat_gate, ack_window, write_en, wr_release, check_light, branch_cond;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plotter_wr_ctrl #(.CHAR_W(CHAR_W)) u_plotter_wr_ctrl (
        .clk(clk), .rst(rst), .svc_resp(svc_resp), .plot_ack(plot_ack),
        .rec_mark(rec_mark), .op_mode(op_mode), .wr_start(wr_start),
        .char_strobe(char_strobe), .out_char(out_char), .icycle_rst(icycle_rst),
        .chk_reset_key(chk_reset_key), .branch_test(branch_test),
        .xlat_gate(xlat_gate), .ack_window(ack_window), .write_en(write_en),
        .wr_release(wr_release), .check_light(check_light), .branch_cond(branch_cond)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled 1 time unit after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        svc_resp = 0; plot_ack = 0; rec_mark = 0; wr_start = 0; char_strobe = 0;
        op_mode = 2'b00; out_char = '0; icycle_rst = 0; chk_reset_key = 0; branch_test = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1;
        step(); step();
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "gate", xlat_gate, 0);
        check("R1", "window", ack_window, 0);
        check("R1", "write_en", write_en, 0);
        check("R1", "release", wr_release, 0);
        check("R1", "light", check_light, 0);
        check("R1", "branch", branch_cond, 0);
    endtask

    task automatic t_gate();
        svc_resp = 1; step(); svc_resp = 0;
        check("R2", "gate set", xlat_gate, 1);
        step();
        check("R2", "gate held", xlat_gate, 1);
        plot_ack = 1; step(); plot_ack = 0;
        check("R2", "gate cleared by ack", xlat_gate, 0);
        svc_resp = 1; plot_ack = 1; step(); svc_resp = 0; plot_ack = 0;
        check("R2", "set wins", xlat_gate, 1);
        plot_ack = 1; step(); plot_ack = 0;
        step();
    endtask

    task automatic t_window();
        plot_ack = 1; step(); plot_ack = 0;
        check("R3", "window open", ack_window, 1);
        step();
        check("R3", "window closed", ack_window, 0);
        plot_ack = 1;
        step(); check("R3", "held ack 1", ack_window, 1);
        step(); check("R3", "held ack 0", ack_window, 0);
        step(); check("R3", "held ack 1 again", ack_window, 1);
        plot_ack = 0; step();
    endtask

    task automatic t_write_mark(input logic [1:0] mode, input string req);
        op_mode = 2'b00; wr_start = 1; step(); wr_start = 0;
        check("R4", "none mode ignored", write_en, 0);
        op_mode = mode; wr_start = 1; step(); wr_start = 0;
        check("R4", "write on", write_en, 1);
        rec_mark = 1; step(); step();
        check(req, "mark outside window", wr_release, 0);
        plot_ack = 1; step(); plot_ack = 0;
        check(req, "window with mark", ack_window, 1);
        step(); rec_mark = 0;
        check(req, "release set", wr_release, 1);
        check(req, "write blocked", write_en, 0);
        step(); step();
        check("R7", "release held", wr_release, 1);
        icycle_rst = 1; plot_ack = 0; step(); icycle_rst = 0;
        check("R7", "release cleared", wr_release, 0);
        check("R7", "write latch off", write_en, 0);
        op_mode = 2'b00;
    endtask

    task automatic t_release_set_wins();
        op_mode = 2'b01; wr_start = 1; step(); wr_start = 0;
        plot_ack = 1; step(); plot_ack = 0;
        rec_mark = 1; icycle_rst = 1; step(); rec_mark = 0; icycle_rst = 0;
        check("R7", "set beats icycle reset", wr_release, 1);
        icycle_rst = 1; step(); icycle_rst = 0;
        op_mode = 2'b00;
    endtask

    task automatic t_dump();
        op_mode = 2'b10; wr_start = 1; step(); wr_start = 0;
        rec_mark = 1; plot_ack = 1; step(); plot_ack = 0;
        step(); step(); rec_mark = 0;
        check("R6", "dump no release", wr_release, 0);
        check("R6", "dump keeps writing", write_en, 1);
        icycle_rst = 1; step(); icycle_rst = 0;
        check("R7", "icycle ends dump", write_en, 0);
        op_mode = 2'b00;
    endtask

    task automatic t_check();
        svc_resp = 1; step(); svc_resp = 0;
        char_strobe = 1; out_char = 6'b000001; step();
        check("R8", "odd no set", check_light, 0);
        out_char = 6'b110111; step();
        check("R8", "odd five no set", check_light, 0);
        out_char = 6'b111111; step(); char_strobe = 0;
        check("R8", "even sets", check_light, 1);
        chk_reset_key = 1; step(); chk_reset_key = 0;
        check("R9", "key clears", check_light, 0);
        plot_ack = 1; step(); plot_ack = 0;
        char_strobe = 1; out_char = 6'b000000; step(); char_strobe = 0;
        check("R8", "gate low no set", check_light, 0);
        svc_resp = 1; step(); svc_resp = 0;
        char_strobe = 1; out_char = 6'b000000; step(); char_strobe = 0;
        check("R8", "zero is even", check_light, 1);
    endtask

    task automatic t_branch();
        branch_test = 1; #1;
        check("R10", "branch sees latch", branch_cond, 1);
        check("R10", "light on", check_light, 1);
        step(); branch_test = 0;
        check("R9", "branch clears", branch_cond, 0);
        char_strobe = 1; out_char = 6'b000011; chk_reset_key = 1; step();
        char_strobe = 0; chk_reset_key = 0;
        check("R9", "set wins over key", check_light, 1);
        branch_test = 1; step(); branch_test = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_gate();
        t_window();
        t_write_mark(2'b01, "R5");
        t_write_mark(2'b11, "R5");
        t_release_set_wins();
        t_dump();
        t_check();
        t_branch();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule